// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator CPU

This block is a small stored-program processor with an 8-bit datapath. It has a 4-bit program counter and a 16-word memory that holds both code and data. Its registers are an accumulator, a second operand register, an instruction register, an address register, an output register and a two-bit flag register holding carry and zero. A step counter and a combinational decoder together form the control word for every clock. That control word selects which single source drives the internal bus, which is a multiplexer. It also picks the registers that capture the bus.

After reset the block waits in a load phase. The memory image arrives as a valid/ready stream of address/data beats. A beat moves only on a cycle where both `ld_valid` and `ld_ready` are high, and the sender must hold the beat until then. `ld_ready` is high for the whole load phase. The beat that carries `ld_last` ends the load phase and starts execution at address 0. After that, `ld_ready` stays low until the next reset, and any beat offered is not consumed. Results leave through `out_data` with a one-cycle `out_valid` strobe. That strobe has no back-pressure, so the consumer must take the value in the cycle it is flagged. `halted` reports that a halt instruction has stopped the machine.

Each instruction spends two steps fetching. It then runs only as many execute steps as it needs, because the last of those steps returns the step counter to zero.

Top module: `teach_cpu`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `out_data` is 0, `out_valid` is 0, `halted` is 0 and `ld_ready` is 1. The accumulator resets to 0.
- R2: A load beat (`ld_valid` and `ld_ready` both high at a clock edge) writes `ld_data` into memory word `ld_addr`. The beat with `ld_last` high also starts execution at address 0 and drops `ld_ready` at that same edge. Beats offered after that edge leave memory and results unchanged.
- R3: An instruction byte holds the opcode in bits 7:4 and the operand in bits 3:0. The codes are: 0 no-op, 1 load A from memory, 2 add memory to A, 3 subtract memory from A, 4 store A to memory, 5 load the operand into A as an immediate, 6 jump, 7 jump if carry, 8 jump if zero, 14 output A, 15 halt. Codes 9 to 13 act as no-ops.
- R4: Add computes A + M mod 256. Subtract computes A + (~M) + 1 mod 256.
- R5: Carry is bit 8 of the 9-bit sum used by add or subtract. Zero is 1 exactly when the 8-bit result is 0. Both flags change only on add and subtract.
- R6: Jump-if-carry is taken when carry is 1. Jump-if-zero is taken when zero is 1. A taken jump loads the operand into the PC. A jump that is not taken continues at the next address.
- R7: With E0 as the clock edge that accepts the last load beat, the first instruction starts at edge 1. Each instruction lasts two fetch edges plus its execute edges, and the next instruction starts at the following edge. Add and subtract take 3 execute edges. Load A and store take 2. Every other code takes 1.
- R8: An output instruction starting at edge s copies A to `out_data` and raises `out_valid` for the single cycle after edge s+2. `out_data` changes at no other time.
- R9: A halt starting at edge s raises `halted` after edge s+2. From then on no register or memory word changes and no strobe appears until reset.
- R10: Store writes A to the memory word named by the operand. The stored value is visible to later loads and to later fetches.
- R11: A Fibonacci program emits 0, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233 in order and then halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be accepted (load phase only) |
| ld_last | input | 1 | Final beat of the image; starts execution |
| ld_addr | input | 4 | Memory word to write |
| ld_data | input | 8 | Byte to write |
| out_data | output | 8 | Output register |
| out_valid | output | 1 | One-cycle strobe when the output register is written |
| halted | output | 1 | Machine stopped by halt until reset |

## Verification
The only outputs are the stream of output values, with their timing, and the halt flag. A wrong step count, a flag updated at the wrong step or a dropped counter reset therefore shows up as an output strobe at the wrong cycle or with the wrong value. The first output instruction after the fault exposes it. Corrupted memory or accumulator state may stay hidden until a later output or a jump depends on it. For that reason the bench compares every strobe's value and cycle against an instruction-level model, using both random and directed programs, and it compares the cycle at which halt is reached.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int STEP_W = 3;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_NOP = 4'd0;
  localparam logic [OP_W-1:0] OP_LDA = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB = 4'd3;
  localparam logic [OP_W-1:0] OP_STA = 4'd4;
  localparam logic [OP_W-1:0] OP_LDI = 4'd5;
  localparam logic [OP_W-1:0] OP_JMP = 4'd6;
  localparam logic [OP_W-1:0] OP_JC  = 4'd7;
  localparam logic [OP_W-1:0] OP_JZ  = 4'd8;
  localparam logic [OP_W-1:0] OP_OUT = 4'd14;
  localparam logic [OP_W-1:0] OP_HLT = 4'd15;

  // one control word per step
  typedef struct packed {
    logic stop;      // freeze machine
    logic mar_ld;    // address register captures bus
    logic mem_wr;    // memory captures bus
    logic mem_oe;    // memory drives bus
    logic opd_oe;    // operand field drives bus
    logic ir_ld;     // instruction register captures bus
    logic acc_ld;    // accumulator captures bus
    logic acc_oe;    // accumulator drives bus
    logic alu_oe;    // ALU drives bus, flags capture
    logic alu_sub;   // ALU subtracts
    logic opb_ld;    // operand register captures bus
    logic out_ld;    // output register captures bus
    logic pc_inc;    // program counter increments
    logic pc_oe;     // program counter drives bus
    logic pc_ld;     // program counter captures bus
    logic step_clr;  // step counter returns to zero
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_STOP = 2'd2
  } mode_e;

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [STEP_W-1:0] step,
  input  logic              flag_c,
  input  logic              flag_z,
  output ctrl_t             cw
);

  localparam logic [STEP_W-1:0] S_ADDR  = STEP_W'(0);
  localparam logic [STEP_W-1:0] S_FETCH = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_EX0   = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_EX1   = STEP_W'(3);

  always_comb begin
    cw = '0;
    case (step)
      S_ADDR: begin
        cw.pc_oe  = 1'b1;
        cw.mar_ld = 1'b1;
      end
      S_FETCH: begin
        cw.mem_oe = 1'b1;
        cw.ir_ld  = 1'b1;
        cw.pc_inc = 1'b1;
      end
      default: begin
        case (opcode)
          OP_LDA: begin
            if (step == S_EX0) begin
              cw.opd_oe = 1'b1;
              cw.mar_ld = 1'b1;
            end else begin
              cw.mem_oe   = 1'b1;
              cw.acc_ld   = 1'b1;
              cw.step_clr = 1'b1;
            end
          end
          OP_ADD, OP_SUB: begin
            cw.alu_sub = (opcode == OP_SUB);
            if (step == S_EX0) begin
              cw.opd_oe = 1'b1;
              cw.mar_ld = 1'b1;
            end else if (step == S_EX1) begin
              cw.mem_oe = 1'b1;
              cw.opb_ld = 1'b1;
            end else begin
              cw.alu_oe   = 1'b1;
              cw.acc_ld   = 1'b1;
              cw.step_clr = 1'b1;
            end
          end
          OP_STA: begin
            if (step == S_EX0) begin
              cw.opd_oe = 1'b1;
              cw.mar_ld = 1'b1;
            end else begin
              cw.acc_oe   = 1'b1;
              cw.mem_wr   = 1'b1;
              cw.step_clr = 1'b1;
            end
          end
          OP_LDI: begin
            cw.opd_oe   = 1'b1;
            cw.acc_ld   = 1'b1;
            cw.step_clr = 1'b1;
          end
          OP_JMP: begin
            cw.opd_oe   = 1'b1;
            cw.pc_ld    = 1'b1;
            cw.step_clr = 1'b1;
          end
          OP_JC: begin
            cw.opd_oe   = flag_c;
            cw.pc_ld    = flag_c;
            cw.step_clr = 1'b1;
          end
          OP_JZ: begin
            cw.opd_oe   = flag_z;
            cw.pc_ld    = flag_z;
            cw.step_clr = 1'b1;
          end
          OP_OUT: begin
            cw.acc_oe   = 1'b1;
            cw.out_ld   = 1'b1;
            cw.step_clr = 1'b1;
          end
          OP_HLT: begin
            cw.stop = 1'b1;
          end
          default: begin
            cw.step_clr = 1'b1;
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ctrl_t             cw,
  output logic              loading,
  output logic              running,
  output logic              stopped,
  output logic [STEP_W-1:0] step
);

  mode_e mode_q;

  assign loading = (mode_q == MODE_LOAD);
  assign running = (mode_q == MODE_RUN);
  assign stopped = (mode_q == MODE_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LOAD;
      step   <= '0;
    end else begin
      case (mode_q)
        MODE_LOAD: begin
          if (start) begin
            mode_q <= MODE_RUN;
            step   <= '0;
          end
        end
        MODE_RUN: begin
          if (cw.stop) begin
            mode_q <= MODE_STOP;
          end else if (cw.step_clr) begin
            step <= '0;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        default: mode_q <= MODE_STOP;
      endcase
    end
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] result,
  output logic         carry,
  output logic         zero
);

  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  assign b_eff  = sub ? ~b : b;
  assign sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign result = sum[W-1:0];
  assign carry  = sum[W];
  assign zero   = (sum[W-1:0] == '0);

endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/teach_cpu.sv
module teach_cpu
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_last,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);

  localparam int OPC_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, acc_q, opb_q, bus;
  logic              flag_c_q, flag_z_q;
  logic [DATA_W-1:0] mem_rd, alu_res;
  logic              alu_c, alu_z;
  logic              loading, running, stopped;
  logic [STEP_W-1:0] step;
  ctrl_t             cw_raw, cw;
  logic              ld_fire, start;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [DATA_W-1:0] mem_wd;
  logic [OPC_W-1:0]  opcode;

  assign ld_ready = loading;
  assign ld_fire  = ld_valid & ld_ready;
  assign start    = ld_fire & ld_last;
  assign halted   = stopped;
  assign opcode   = ir_q[DATA_W-1:ADDR_W];

  cpu_decode u_decode (
    .opcode (opcode),
    .step   (step),
    .flag_c (flag_c_q),
    .flag_z (flag_z_q),
    .cw     (cw_raw)
  );

  // control is inert outside the run phase
  assign cw = running ? cw_raw : '0;

  cpu_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cw      (cw),
    .loading (loading),
    .running (running),
    .stopped (stopped),
    .step    (step)
  );

  cpu_alu #(.W(DATA_W)) u_alu (
    .a      (acc_q),
    .b      (opb_q),
    .sub    (cw.alu_sub),
    .result (alu_res),
    .carry  (alu_c),
    .zero   (alu_z)
  );

  assign mem_we = ld_fire | cw.mem_wr;
  assign mem_wa = ld_fire ? ld_addr : mar_q;
  assign mem_wd = ld_fire ? ld_data : bus;

  cpu_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (mem_wa),
    .wr_data (mem_wd),
    .rd_addr (mar_q),
    .rd_data (mem_rd)
  );

  // bus multiplexer: at most one source enabled per step
  always_comb begin
    bus = '0;
    if (cw.pc_oe)  bus = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
    if (cw.mem_oe) bus = mem_rd;
    if (cw.opd_oe) bus = {{(DATA_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
    if (cw.acc_oe) bus = acc_q;
    if (cw.alu_oe) bus = alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      mar_q     <= '0;
      ir_q      <= '0;
      acc_q     <= '0;
      opb_q     <= '0;
      flag_c_q  <= 1'b0;
      flag_z_q  <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= cw.out_ld;
      if (cw.mar_ld) mar_q    <= bus[ADDR_W-1:0];
      if (cw.ir_ld)  ir_q     <= bus;
      if (cw.acc_ld) acc_q    <= bus;
      if (cw.opb_ld) opb_q    <= bus;
      if (cw.out_ld) out_data <= bus;
      if (cw.pc_ld)       pc_q <= bus[ADDR_W-1:0];
      else if (cw.pc_inc) pc_q <= pc_q + ADDR_W'(1);
      if (cw.alu_oe) begin
        flag_c_q <= alu_c;
        flag_z_q <= alu_z;
      end
    end
  end

endmodule

// File: rtl/cpu_checker.sv
module cpu_checker
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              halted,
  input logic [STEP_W-1:0] step
);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(out_data) && !out_valid));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r8_data_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data != $past(out_data)) |-> out_valid);

  a_r2_no_load_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || halted) |-> !ld_ready);

  a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_W'(4));

endmodule

bind teach_cpu cpu_checker #(.DATA_W(DATA_W)) u_cpu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_ready  (ld_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .halted    (halted),
  .step      (step)
);

// File: tb/test_teach_cpu.sv
module test_teach_cpu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_last = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       ld_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       halted;

  always #5 clk = ~clk;

  teach_cpu i_teach_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .ld_last   (ld_last),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .halted    (halted)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] img [16];
  int exp_val [256]; int exp_t [256]; int exp_n; bit exp_halt; int exp_ht;
  int got_val [256]; int got_t [256]; int got_n; int got_ht;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // instruction-level model built from R3..R10; start edge of first instruction is 1
  task automatic model_run(input int win);
    logic [7:0] m [16];
    logic [3:0] pc;
    logic [7:0] a, ir;
    logic [8:0] sum;
    logic       c, z;
    int s, len;
    for (int i = 0; i < 16; i++) m[i] = img[i];
    pc = '0; a = '0; c = 1'b0; z = 1'b0; s = 1;
    exp_n = 0; exp_halt = 1'b0; exp_ht = 0;
    while (s + 2 <= win) begin
      ir = m[pc];
      pc = pc + 4'd1;
      len = 3;
      case (ir[7:4])
        4'd1: begin a = m[ir[3:0]]; len = 4; end
        4'd2, 4'd3: begin
          if (ir[7:4] == 4'd2) sum = {1'b0, a} + {1'b0, m[ir[3:0]]};
          else                 sum = {1'b0, a} + {1'b0, ~m[ir[3:0]]} + 9'd1;
          a = sum[7:0]; c = sum[8]; z = (sum[7:0] == 8'd0); len = 5;
        end
        4'd4: begin m[ir[3:0]] = a; len = 4; end
        4'd5: a = {4'd0, ir[3:0]};
        4'd6: pc = ir[3:0];
        4'd7: if (c) pc = ir[3:0];
        4'd8: if (z) pc = ir[3:0];
        4'd14: begin exp_val[exp_n] = a; exp_t[exp_n] = s + 2; exp_n++; end
        4'd15: begin exp_halt = 1'b1; exp_ht = s + 2; break; end
        default: len = 3;
      endcase
      s += len;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ld_valid = 1'b0;
    ld_last = 1'b0;
    repeat (2) @(negedge clk);
    check(out_data == 8'd0 && !out_valid, "R1 outputs in reset", out_data, 0);
    check(!halted && ld_ready, "R1 halted/ready in reset", {halted, ld_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ld_ready && !halted && !out_valid, "R1 after release", {ld_ready, halted, out_valid}, 4);
  endtask

  task automatic load_image(input bit shuffle);
    int idx [16];
    for (int i = 0; i < 16; i++) idx[i] = i;
    if (shuffle) begin
      for (int i = 15; i > 0; i--) begin
        int j, t;
        j = $urandom_range(0, i);
        t = idx[i]; idx[i] = idx[j]; idx[j] = t;
      end
    end
    for (int i = 0; i < 16; i++) begin
      ld_valid = 1'b1;
      ld_addr  = idx[i][3:0];
      ld_data  = img[idx[i]];
      ld_last  = (i == 15);
      @(posedge clk);
      @(negedge clk);
      if (i == 15) check(!ld_ready, "R2 ready drops after last", ld_ready, 0);
    end
    ld_valid = 1'b0;
    ld_last  = 1'b0;
  endtask

  // load_image ends one negedge after E0; edge 1 is the next posedge
  task automatic run_dut(input int win, input bit junk);
    got_n = 0; got_ht = 0;
    for (int k = 1; k <= win; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
        got_val[got_n] = out_data; got_t[got_n] = k; got_n++;
      end
      if (halted && got_ht == 0) got_ht = k;
      if (junk) begin
        ld_valid = $urandom_range(0, 1);
        ld_last  = $urandom_range(0, 1);
        ld_addr  = 4'($urandom_range(0, 15));
        ld_data  = 8'($urandom_range(0, 255));
      end
    end
    ld_valid = 1'b0;
    ld_last  = 1'b0;
  endtask

  task automatic compare(input int win);
    int lim;
    model_run(win);
    check(got_n == exp_n, "R7 number of strobes", got_n, exp_n);
    lim = (got_n < exp_n) ? got_n : exp_n;
    for (int i = 0; i < lim; i++) begin
      check(got_val[i] == exp_val[i], "R4 strobe value", got_val[i], exp_val[i]);
      check(got_t[i] == exp_t[i], "R7 strobe cycle", got_t[i], exp_t[i]);
    end
    check((got_ht != 0) == exp_halt, "R9 halt reached", got_ht != 0, exp_halt);
    if (exp_halt) check(got_ht == exp_ht, "R9 halt cycle", got_ht, exp_ht);
  endtask

  function automatic logic [7:0] rand_word();
    logic [3:0] op;
    op = 4'($urandom_range(0, 15));
    if (op == 4'd15 && $urandom_range(0, 2) != 0) op = 4'd14;
    return {op, 4'($urandom_range(0, 15))};
  endfunction

  initial begin
    int fib [13];
    void'($urandom(32'd4242));
    fib = '{0, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233};

    // R11 Fibonacci, with load beats offered during the run (R2 ignored)
    img = '{8'hE0, 8'h51, 8'h4E, 8'hE0, 8'h4D, 8'h2E, 8'h7C, 8'h4F,
            8'h1D, 8'h4E, 8'h1F, 8'h63, 8'hF0, 8'h00, 8'h00, 8'h00};
    do_reset();
    load_image(1'b0);
    run_dut(600, 1'b1);
    check(got_n == 13, "R11 fibonacci count", got_n, 13);
    for (int i = 0; i < 13 && i < got_n; i++)
      check(got_val[i] == fib[i], "R11 fibonacci value", got_val[i], fib[i]);
    check(halted, "R11 halts after 233", halted, 1);
    check(!ld_ready, "R2 ready stays low when halted", ld_ready, 0);
    compare(600);

    // R4 R5 R6 R7: 3 - 5 = 254, carry 0, jump-if-carry not taken
    img = '{8'h53, 8'h3F, 8'h75, 8'hE0, 8'hF0, 8'hE0, 8'h00, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05};
    do_reset();
    load_image(1'b1);
    run_dut(60, 1'b0);
    check(got_n == 1 && got_val[0] == 254, "R4 subtract wraps", got_val[0], 254);
    check(got_t[0] == 14, "R7 output cycle after sub+jc", got_t[0], 14);
    check(got_ht == 17, "R9 halt cycle", got_ht, 17);

    // R5 R6: 5 - 5 = 0, zero and carry set, both jumps taken
    img = '{8'h55, 8'h3F, 8'h84, 8'hF0, 8'h76, 8'hF0, 8'hE0, 8'hF0,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05};
    do_reset();
    load_image(1'b1);
    run_dut(60, 1'b0);
    check(got_n == 1 && got_val[0] == 0, "R6 jz and jc taken", got_n, 1);
    check(got_t[0] == 17, "R7 output cycle after jumps", got_t[0], 17);

    // R3 undefined codes 9..13 act as no-ops
    img = '{8'h57, 8'h9A, 8'hD3, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    do_reset();
    load_image(1'b1);
    run_dut(40, 1'b0);
    check(got_n == 1 && got_val[0] == 7, "R3 undefined as no-op value", got_val[0], 7);
    check(got_t[0] == 12, "R3 undefined as no-op timing", got_t[0], 12);

    // R10 store then fetch of the stored word (self-modifying)
    img = '{8'h1E, 8'h43, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hE0, 8'h00};
    do_reset();
    load_image(1'b0);
    run_dut(40, 1'b0);
    check(got_n == 1 && got_val[0] == 8'hE0, "R10 stored word executed", got_val[0], 8'hE0);
    compare(40);

    // random programs against the model
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 16; i++) img[i] = rand_word();
      do_reset();
      load_image(1'b1);
      run_dut(300, p[0]);
      compare(300);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule